// File: doc/BRIEF.md
# LIN Node Wake-Up Qualifier

This block decides when a dormant LIN node has really been asked to wake. While the mode controller holds the node in Silent or Sleep, the block watches two asynchronous inputs: the receive level of the bus (high is recessive) and an active-low local wake input. A wake counts only when a line goes from high to low and then stays low for a minimum time. The bus and the local input each have their own filter time. The local time is longer so that short disturbances on the wake wire are rejected.

When a wake qualifies, the block sends a one-cycle request to the mode controller. It also latches a wake flag and the identity of the source that caused the wake. Once the node is back in Pre Normal, the flag is reported by a bit that pulls the receive data pin low. The source is reported by choosing a strong or a weak pull-down on the transmit data pin: strong means local, weak means bus. Raising the enable input clears both flags at once. Analog thresholds and pin drivers are outside the block; it only produces control bits.

Top module: `lin_wake_qualifier`

## Requirements
- R1: During and after reset, with no wake activity, all four outputs are 0.
- R2: In Silent (mode 2'b10) or Sleep (mode 2'b11), a high-to-low change on `bus_rx_i` followed by a low level held for more than `BUS_FILT_CYC` clock cycles produces a wake, and the source is recorded as bus.
- R3: A low level on either input that ends before its filter time produces no wake. The filter restarts on the next falling edge, so a series of short low pulses never adds up to a wake.
- R4: In Silent or Sleep, a high-to-low change on `wake_n_i` followed by a low level held for more than `LOCAL_FILT_CYC` cycles produces a wake, and the source is recorded as local.
- R5: A wake needs a falling edge seen while the block is armed. A line that is already low when Silent or Sleep is entered produces no wake, however long it stays low.
- R6: Detection is armed only in Silent and Sleep. Low levels seen in Pre Normal (2'b00) or Normal (2'b01) produce no wake.
- R7: The flag outputs report only in Pre Normal, and only while `en_i` is low. There, `rxd_low_o` is 1 after a wake, `txd_pd_strong_o` is 1 for a local source, and `txd_pd_weak_o` is 1 for a bus source. The two pull-down outputs are never 1 together.
- R8: `en_i` high forces all reporting outputs to 0 in the same cycle and clears the stored flag and source, so they stay 0 after `en_i` returns low.
- R9: If both sources qualify in the same cycle, the source is recorded as local.
- R10: Once a wake is latched, a later qualification from the other source changes neither the recorded source nor the request count until the flags are cleared.
- R11: `wake_req_o` is a single-cycle pulse, issued once per latched wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Current node mode: 00 Pre Normal, 01 Normal, 10 Silent, 11 Sleep |
| en_i | input | 1 | Enable from the microcontroller (synchronous); high clears the flags |
| bus_rx_i | input | 1 | Asynchronous bus receive level, 1 = recessive |
| wake_n_i | input | 1 | Asynchronous local wake input, active low |
| wake_req_o | output | 1 | One-cycle wake request to the mode controller |
| rxd_low_o | output | 1 | Pull the receive data pin low to signal a wake |
| txd_pd_strong_o | output | 1 | Strong pull-down on the transmit data pin (local source) |
| txd_pd_weak_o | output | 1 | Weak pull-down on the transmit data pin (bus source) |

## Verification
The assertions assume that `mode_i` and `en_i` are synchronous to `clk`. They also assume that the mode controller has moved the node out of Silent or Sleep before it raises `en_i` to clear the flags, so that clear and report never compete in a way the checks would misread. The stimulus changes every input only on the falling clock edge. It steps the mode from Pre Normal into Silent or Sleep and back, and it raises the enable only from Pre Normal. Randomly drawn low-pulse lengths are kept at least four cycles away from each filter threshold, so the two-stage synchronizer delay cannot decide the expected outcome.

// File: rtl/lin_wake_pkg.sv
// Package: shared mode encoding and helpers for the LIN wake-up qualifier.
// Assumes the mode controller presents its state with this 2-bit code.
package lin_wake_pkg;

    typedef enum logic [1:0] {
        MODE_PRENORM = 2'b00,
        MODE_NORMAL  = 2'b01,
        MODE_SILENT  = 2'b10,
        MODE_SLEEP   = 2'b11
    } lin_mode_e;

    // Wake detection is armed only in the two low-power modes.
    function automatic logic mode_is_armed(input logic [1:0] m);
        return (m == MODE_SILENT) || (m == MODE_SLEEP);
    endfunction

    // Flags are reported only in Pre Normal.
    function automatic logic mode_is_report(input logic [1:0] m);
        return (m == MODE_PRENORM);
    endfunction

endpackage

// File: rtl/lin_wake_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous levels.
// Assumes each bit is independent (no multi-bit coherency needed).
// Reset loads RST_VAL, which is the idle level of the inputs.
module lin_wake_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Later stages let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/lin_wake_filter.sv
// Module: falling-edge-then-hold filter for one active-low wake source.
// Starts counting on a high-to-low change seen while armed. It fires qual_o
// for one cycle once the level has stayed low for FILT_CYC further cycles.
// Any high sample, or disarming, abandons the attempt.
// Assumes lvl_i is already synchronous to clk.
module lin_wake_filter #(
    parameter int FILT_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed_i,
    input  logic lvl_i,
    output logic qual_o
);
    localparam int              CW   = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0]   LAST = CW'(FILT_CYC);

    logic          prev_q;
    logic          active_q;
    logic [CW-1:0] cnt_q;
    logic          fall;

    assign fall   = armed_i && prev_q && !lvl_i;
    assign qual_o = active_q && armed_i && !lvl_i && (cnt_q == LAST);

    // Remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl_i;
    end

    // Count the low time after a qualifying falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (!armed_i || lvl_i) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (fall) begin
            active_q <= 1'b1;
            cnt_q    <= CW'(1);
        end else if (active_q) begin
            if (cnt_q == LAST) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // R3: the filter count stays within its window.
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R2/R4: a qualification is always preceded by a low sample.
    assert_qual_after_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |-> !$past(lvl_i));

endmodule

// File: rtl/lin_wake_flags.sv
// Module: wake flag and source latch with request pulse and reporting.
// Latches the first qualification (local wins a tie). Holds the source until
// clr_i. Outputs report only while report_i is high and clr_i is low.
// Assumes clr_i and report_i are synchronous to clk.
module lin_wake_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic armed_i,
    input  logic report_i,
    input  logic clr_i,
    input  logic qual_bus_i,
    input  logic qual_loc_i,
    output logic wake_req_o,
    output logic rxd_low_o,
    output logic pd_strong_o,
    output logic pd_weak_o
);
    logic flag_q;
    logic src_loc_q;
    logic req_q;
    logic take;
    logic show;

    assign take = armed_i && !flag_q && !clr_i && (qual_bus_i || qual_loc_i);

    // Latch the wake flag and its source; clear on enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q    <= 1'b0;
            src_loc_q <= 1'b0;
        end else if (clr_i) begin
            flag_q    <= 1'b0;
            src_loc_q <= 1'b0;
        end else if (take) begin
            flag_q    <= 1'b1;
            src_loc_q <= qual_loc_i;
        end
    end

    // One-cycle request to the mode controller.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= take;
    end

    assign show        = flag_q && report_i && !clr_i;
    assign wake_req_o  = req_q;
    assign rxd_low_o   = show;
    assign pd_strong_o = show && src_loc_q;
    assign pd_weak_o   = show && !src_loc_q;

    // R8: an enable cycle leaves no stored flag.
    assert_clear_on_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !flag_q);

    // R10: a held flag keeps its source.
    assert_src_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && $past(flag_q)) |-> (src_loc_q == $past(src_loc_q)));

    // R11: the request never lasts two cycles.
    assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |=> !wake_req_o);

    // R7: pull-down strengths are exclusive.
    assert_pd_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pd_strong_o && pd_weak_o));

endmodule

// File: rtl/lin_wake_qualifier.sv
// Module: top of the LIN wake-up qualifier.
// Synchronizes the bus receive level and the local wake input. Filters each
// with its own hold time, and latches/reports the wake and its source.
// Assumes mode_i and en_i come from logic clocked by clk.
module lin_wake_qualifier
    import lin_wake_pkg::*;
#(
    parameter int BUS_FILT_CYC   = 11250,
    parameter int LOCAL_FILT_CYC = 25000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       en_i,
    input  logic       bus_rx_i,
    input  logic       wake_n_i,
    output logic       wake_req_o,
    output logic       rxd_low_o,
    output logic       txd_pd_strong_o,
    output logic       txd_pd_weak_o
);
    localparam int NSRC = 2;
    localparam int IDX_BUS = 0;
    localparam int IDX_LOC = 1;

    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] lvl;
    logic [NSRC-1:0] qual;
    logic            armed;
    logic            report;

    assign raw[IDX_BUS] = bus_rx_i;
    assign raw[IDX_LOC] = wake_n_i;
    assign armed  = mode_is_armed(mode_i);
    assign report = mode_is_report(mode_i);

    lin_wake_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (lvl)
    );

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_filt
            localparam int FC = (i == IDX_BUS) ? BUS_FILT_CYC : LOCAL_FILT_CYC;
            lin_wake_filter #(.FILT_CYC(FC)) u_filt (
                .clk     (clk),
                .rst_n   (rst_n),
                .armed_i (armed),
                .lvl_i   (lvl[i]),
                .qual_o  (qual[i])
            );
        end
    endgenerate

    lin_wake_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .armed_i     (armed),
        .report_i    (report),
        .clr_i       (en_i),
        .qual_bus_i  (qual[IDX_BUS]),
        .qual_loc_i  (qual[IDX_LOC]),
        .wake_req_o  (wake_req_o),
        .rxd_low_o   (rxd_low_o),
        .pd_strong_o (txd_pd_strong_o),
        .pd_weak_o   (txd_pd_weak_o)
    );

    // R6: a request follows only a cycle spent armed.
    assert_req_only_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> mode_is_armed($past(mode_i)));

    // R7: reporting happens only in Pre Normal with enable low.
    assert_report_prenorm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rxd_low_o |-> (mode_i == MODE_PRENORM && !en_i));

endmodule

// File: tb/lin_wake_qualifier_bench.sv
module lin_wake_qualifier_bench;
    localparam int BF = 40;
    localparam int LF = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       en = 1'b0;
    logic       bus = 1'b1;
    logic       wk = 1'b1;
    logic       req, rxl, pds, pdw;

    int checks = 0;
    int fails = 0;
    int req_cnt = 0;
    int seed = 32'h5EED;
    bit done = 0;

    always #4 clk = ~clk;

    lin_wake_qualifier #(.BUS_FILT_CYC(BF), .LOCAL_FILT_CYC(LF)) u_lin_wake_qualifier (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .en_i(en),
        .bus_rx_i(bus), .wake_n_i(wk), .wake_req_o(req),
        .rxd_low_o(rxl), .txd_pd_strong_o(pds), .txd_pd_weak_o(pdw)
    );

    // Count request cycles (R11 pulse counting).
    always @(negedge clk) if (rst_n && req) req_cnt++;

    function automatic bit exp_wake(input int len, input int filt);
        return len > filt;
    endfunction

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string r, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0b exp=%0b", r, act, exp);
        end
    endtask

    task automatic chk_int(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", r, act, exp);
        end
    endtask

    // Clear flags from Pre Normal, then enter the given mode.
    task automatic prep(input logic [1:0] m);
        mode = 2'b00; en = 1'b1; bus = 1'b1; wk = 1'b1;
        step(3);
        en = 1'b0; mode = m;
        step(5);
    endtask

    task automatic report_check(input string r, input logic e_w, input logic e_loc);
        step(8);
        mode = 2'b00;
        step(1);
        chk(r, rxl, e_w);
        chk(r, pds, e_w & e_loc);
        chk(r, pdw, e_w & ~e_loc);
    endtask

    initial begin
        int base;
        step(4);
        chk("R1", req, 0); chk("R1", rxl, 0); chk("R1", pds, 0); chk("R1", pdw, 0);
        rst_n = 1'b1;
        step(3);
        chk("R1", rxl, 0);

        // R2 bus wake
        prep(2'b10); base = req_cnt;
        bus = 0; step(BF + 6); bus = 1;
        report_check("R2", 1, 0);
        chk_int("R11", req_cnt - base, 1);

        // R4 local wake in Sleep
        prep(2'b11); base = req_cnt;
        wk = 0; step(LF + 6); wk = 1;
        report_check("R4", 1, 1);
        chk_int("R11", req_cnt - base, 1);

        // R3 short pulses that would add up
        prep(2'b10); base = req_cnt;
        for (int k = 0; k < 4; k++) begin bus = 0; step(BF - 10); bus = 1; step(3); end
        report_check("R3", 0, 0);
        chk_int("R3", req_cnt - base, 0);

        // R5 already low when armed
        prep(2'b01); base = req_cnt;
        wk = 0; step(6); mode = 2'b10; step(LF + 20);
        report_check("R5", 0, 0);
        wk = 1;
        chk_int("R5", req_cnt - base, 0);

        // R6 not armed in Normal
        prep(2'b01); base = req_cnt;
        bus = 0; step(BF + 10); bus = 1;
        report_check("R6", 0, 0);
        chk_int("R6", req_cnt - base, 0);

        // R8 enable clears immediately and persistently
        prep(2'b10);
        bus = 0; step(BF + 6); bus = 1;
        report_check("R8", 1, 0);
        en = 1'b1; #1;
        chk("R8", rxl, 0); chk("R8", pdw, 0);
        step(1); en = 1'b0; step(2);
        chk("R8", rxl, 0); chk("R8", pdw, 0);

        // R9 both qualify in the same cycle
        prep(2'b10); base = req_cnt;
        wk = 0; step(LF - BF); bus = 0; step(BF + 8); wk = 1; bus = 1;
        report_check("R9", 1, 1);
        chk_int("R9", req_cnt - base, 1);

        // R10 bus first, then local: source stays bus, one request
        prep(2'b11); base = req_cnt;
        bus = 0; step(BF + 6); bus = 1; step(4);
        wk = 0; step(LF + 6); wk = 1;
        report_check("R10", 1, 0);
        chk_int("R10", req_cnt - base, 1);

        // Random pulses kept clear of thresholds
        for (int it = 0; it < 40; it++) begin
            int is_loc, f, len, longp;
            is_loc = $urandom(seed) % 2; seed = seed + 7;
            longp  = $urandom(seed) % 2; seed = seed + 7;
            f = is_loc ? LF : BF;
            len = longp ? (f + 4 + ($urandom(seed) % 30)) : (1 + ($urandom(seed) % (f - 4)));
            seed = seed + 7;
            prep(($urandom(seed) % 2) ? 2'b10 : 2'b11); seed = seed + 7;
            base = req_cnt;
            if (is_loc != 0) wk = 0; else bus = 0;
            step(len);
            wk = 1; bus = 1;
            report_check(is_loc != 0 ? "R4" : "R2", exp_wake(len, f), is_loc != 0);
            chk_int("R11", req_cnt - base, exp_wake(len, f) ? 1 : 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule